// File: doc/BRIEF.md
# Chip-Level Differential Soft Preprocessor

This block sits at the front of a sequential-estimation code acquisition chain. Each chip strobe delivers one complex baseband sample as signed in-phase and quadrature words. The block multiplies the sample by the complex conjugate of the sample taken one chip earlier and keeps only the real part. This removes a carrier phase that changes slowly from chip to chip. The result is then weighted by a channel reliability factor, which gives a signed intrinsic log-likelihood value for that chip. The downstream soft decoder consumes these values.

The reference register holds the previous sample. Reset and the synchronous clear both load it with the complex value one, which lets a new acquisition attempt begin at once. The weighting has two modes. In the equal-gain mode a unity factor is used and the programmed factor is ignored. In the maximal-ratio mode the factor supplied on the gain input is used. No a priori term is added, so both chip polarities are treated as equally likely.

Fixed point: samples carry `IQ_FRAC` fraction bits, the gain carries `REL_FRAC` fraction bits, and the output carries `LLR_FRAC` fraction bits. With the defaults (12-bit samples with 10 fraction bits, 8-bit gain with 4 fraction bits, 8-bit output with 3 fraction bits), the complex one is I=1024, Q=0, the unity gain is 16, and the output equals floor(dot·g / 2^21). In that expression dot = I_k·I_{k-1} + Q_k·Q_{k-1}.

Top module: `diff_llr_front`

## Requirements
- R1: While reset is held and in the first cycle after it, `llr_vld` is 0 and `llr` is 0.
- R2: The first accepted chip after reset uses the reference I=2^IQ_FRAC, Q=0, so its product is I_k·2^IQ_FRAC.
- R3: Every later accepted chip uses the real part of the product with the conjugate of the previous accepted chip, I_k·I_{k-1} + Q_k·Q_{k-1}, at full precision.
- R4: With `rel_mode`=1 (maximal ratio), `llr` = floor(dot·rel_gain / 2^(2·IQ_FRAC+REL_FRAC−LLR_FRAC)). The gain is the one present in the cycle the chip is accepted.
- R5: With `rel_mode`=0 (equal gain), the factor is 2^REL_FRAC and the value on `rel_gain` has no effect on `llr`.
- R6: A scaled result outside the signed LLR_W range is clamped to 2^(LLR_W−1)−1 or −2^(LLR_W−1). It does not wrap.
- R7: A chip strobe accepted at a clock edge gives exactly one `llr_vld` pulse two edges later. No other pulses occur.
- R8: The reference register takes the new sample only on an accepted strobe. Cycles without a strobe leave it unchanged.
- R9: `clr` loads the reference with the complex one. A strobe in the same cycle is dropped and produces no output.
- R10: Between valid pulses `llr` holds the last value it delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous restart of the reference register |
| chip_vld | input | 1 | Chip sample strobe |
| chip_i | input | IQ_W | Signed in-phase sample |
| chip_q | input | IQ_W | Signed quadrature sample |
| rel_mode | input | 1 | 0 equal gain, 1 maximal ratio |
| rel_gain | input | REL_W | Unsigned reliability factor |
| llr_vld | output | 1 | Output strobe |
| llr | output | LLR_W | Signed intrinsic soft value |

## Verification
Directed chips right after reset and after a clear separate a reference of one from a reference of zero or of stale data. A pair of known chips then confirms that both the I and Q cross terms enter with the correct sign. Full-scale chips of both polarities with a large gain reach the clamp at each end, which separates saturation from wrap-around. A long random run mixes strobe gaps, clears, both modes and random gains. It separates a reference that moves on idle cycles from one that does not, and a gain that is honoured from one that is ignored in equal-gain mode. It also checks the latency and the held output on every cycle.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  typedef enum logic {
    REL_EQUAL_GAIN = 1'b0,
    REL_MAX_RATIO  = 1'b1
  } rel_mode_e;
endpackage

// File: rtl/diff_conj_stage.sv
// Reference register plus real part of x_k * conj(x_{k-1}).
module diff_conj_stage #(
  parameter int IQ_W    = 12,
  parameter int IQ_FRAC = 10,
  localparam int DOT_W  = 2 * IQ_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    in_vld,
  input  logic signed [IQ_W-1:0]  in_i,
  input  logic signed [IQ_W-1:0]  in_q,
  output logic                    out_vld,
  output logic signed [DOT_W-1:0] dot,
  output logic signed [IQ_W-1:0]  ref_i,
  output logic signed [IQ_W-1:0]  ref_q
);
  localparam logic signed [IQ_W-1:0] ONE_I = IQ_W'(1 << IQ_FRAC);

  logic accept;
  logic signed [2*IQ_W-1:0] p_ii, p_qq;
  logic signed [DOT_W-1:0]  dot_next;

  assign accept   = in_vld && !clr;
  assign p_ii     = in_i * ref_i;
  assign p_qq     = in_q * ref_q;
  assign dot_next = {p_ii[2*IQ_W-1], p_ii} + {p_qq[2*IQ_W-1], p_qq};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ref_i <= ONE_I;
      ref_q <= '0;
    end else if (in_vld) begin
      ref_i <= in_i;
      ref_q <= in_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      dot     <= '0;
    end else begin
      out_vld <= accept;
      if (accept) dot <= dot_next;
    end
  end
endmodule

// File: rtl/gain_latch.sv
// Captures the effective reliability factor for the chip being accepted.
module gain_latch
  import dlp_pkg::*;
#(
  parameter int G_W    = 8,
  parameter int G_FRAC = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           accept,
  input  logic           mode,
  input  logic [G_W-1:0] gain_in,
  output logic [G_W-1:0] gain_out
);
  localparam logic [G_W-1:0] UNITY = G_W'(1 << G_FRAC);

  rel_mode_e      mode_e;
  logic [G_W-1:0] gain_sel;

  assign mode_e   = rel_mode_e'(mode);
  assign gain_sel = (mode_e == REL_MAX_RATIO) ? gain_in : UNITY;

  always_ff @(posedge clk) begin
    if (rst)         gain_out <= UNITY;
    else if (accept) gain_out <= gain_sel;
  end
endmodule

// File: rtl/llr_scale_stage.sv
// Weights the differential product, rescales and clamps to the LLR width.
module llr_scale_stage #(
  parameter int DOT_W = 25,
  parameter int G_W   = 8,
  parameter int LLR_W = 8,
  parameter int SHIFT = 21,
  localparam int PROD_W = DOT_W + G_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic signed [DOT_W-1:0] dot,
  input  logic [G_W-1:0]          gain,
  output logic                    out_vld,
  output logic signed [LLR_W-1:0] llr
);
  localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((1 << (LLR_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] SAT_LO = ~SAT_HI;

  logic signed [PROD_W-1:0] dot_x, gain_x, prod, scaled;
  logic signed [LLR_W-1:0]  clamped;

  assign dot_x  = {{(G_W + 1){dot[DOT_W-1]}}, dot};
  assign gain_x = {{(DOT_W + 1){1'b0}}, gain};
  assign prod   = dot_x * gain_x;
  assign scaled = prod >>> SHIFT;

  always_comb begin
    if (scaled > SAT_HI)      clamped = SAT_HI[LLR_W-1:0];
    else if (scaled < SAT_LO) clamped = SAT_LO[LLR_W-1:0];
    else                      clamped = scaled[LLR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      llr     <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) llr <= clamped;
    end
  end
endmodule

// File: rtl/diff_llr_front.sv
module diff_llr_front #(
  parameter int IQ_W     = 12,
  parameter int IQ_FRAC  = 10,
  parameter int REL_W    = 8,
  parameter int REL_FRAC = 4,
  parameter int LLR_W    = 8,
  parameter int LLR_FRAC = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    chip_vld,
  input  logic signed [IQ_W-1:0]  chip_i,
  input  logic signed [IQ_W-1:0]  chip_q,
  input  logic                    rel_mode,
  input  logic [REL_W-1:0]        rel_gain,
  output logic                    llr_vld,
  output logic signed [LLR_W-1:0] llr
);
  localparam int DOT_W = 2 * IQ_W + 1;
  localparam int SHIFT = 2 * IQ_FRAC + REL_FRAC - LLR_FRAC;

  logic                    s1_vld;
  logic signed [DOT_W-1:0] s1_dot;
  logic [REL_W-1:0]        s1_gain;
  logic signed [IQ_W-1:0]  prev_i, prev_q;

  diff_conj_stage #(.IQ_W(IQ_W), .IQ_FRAC(IQ_FRAC)) conj_i (
    .clk(clk), .rst(rst), .clr(clr), .in_vld(chip_vld),
    .in_i(chip_i), .in_q(chip_q), .out_vld(s1_vld), .dot(s1_dot),
    .ref_i(prev_i), .ref_q(prev_q)
  );

  gain_latch #(.G_W(REL_W), .G_FRAC(REL_FRAC)) gain_i (
    .clk(clk), .rst(rst), .accept(chip_vld && !clr), .mode(rel_mode),
    .gain_in(rel_gain), .gain_out(s1_gain)
  );

  llr_scale_stage #(.DOT_W(DOT_W), .G_W(REL_W), .LLR_W(LLR_W), .SHIFT(SHIFT)) scale_i (
    .clk(clk), .rst(rst), .in_vld(s1_vld), .dot(s1_dot), .gain(s1_gain),
    .out_vld(llr_vld), .llr(llr)
  );
endmodule

// File: rtl/diff_llr_front_chk.sv
module diff_llr_front_chk #(
  parameter int IQ_W    = 12,
  parameter int IQ_FRAC = 10,
  parameter int LLR_W   = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    clr,
  input logic                    chip_vld,
  input logic signed [IQ_W-1:0]  chip_i,
  input logic signed [IQ_W-1:0]  chip_q,
  input logic                    llr_vld,
  input logic signed [LLR_W-1:0] llr,
  input logic signed [IQ_W-1:0]  prev_i,
  input logic signed [IQ_W-1:0]  prev_q
);
  localparam logic signed [IQ_W-1:0] ONE_I = IQ_W'(1 << IQ_FRAC);

  logic [1:0] since_rst;
  logic       acc;
  assign acc = chip_vld && !clr;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 3)  since_rst <= since_rst + 2'd1;
  end

  // R7: one output pulse per accepted strobe, two edges later
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2) |-> (llr_vld == $past(acc, 2)));

  // R8: accepted strobe becomes the reference
  p_ref_load_r8: assert property (@(posedge clk) disable iff (rst)
    acc |=> (prev_i == $past(chip_i) && prev_q == $past(chip_q)));

  // R8: idle cycles keep the reference
  p_ref_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!chip_vld && !clr) |=> ($stable(prev_i) && $stable(prev_q)));

  // R9: clear restores the complex one
  p_clr_one_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (prev_i == ONE_I && prev_q == '0));

  // R9: strobe together with clear yields no output
  p_clr_drop_r9: assert property (@(posedge clk) disable iff (rst)
    clr |-> ##2 !llr_vld);

  // R10: output holds between pulses
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 0 && !llr_vld) |-> $stable(llr));
endmodule

bind diff_llr_front diff_llr_front_chk #(.IQ_W(IQ_W), .IQ_FRAC(IQ_FRAC), .LLR_W(LLR_W)) chk_i (
  .clk(clk), .rst(rst), .clr(clr), .chip_vld(chip_vld), .chip_i(chip_i),
  .chip_q(chip_q), .llr_vld(llr_vld), .llr(llr), .prev_i(prev_i), .prev_q(prev_q)
);

// File: tb/diff_llr_front_tb_top.sv
`timescale 1ns/1ps
module diff_llr_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IQ_W = 12, IQ_FRAC = 10, REL_W = 8, REL_FRAC = 4;
  localparam int LLR_W = 8, LLR_FRAC = 3;
  localparam int SHIFT = 2 * IQ_FRAC + REL_FRAC - LLR_FRAC;
  localparam int ONE = 1 << IQ_FRAC;
  localparam int UNITY = 1 << REL_FRAC;
  localparam int LMAX = (1 << (LLR_W - 1)) - 1;
  localparam int LMIN = -(1 << (LLR_W - 1));

  logic clk = 0, rst = 1, clr = 0, chip_vld = 0, rel_mode = 0;
  logic signed [IQ_W-1:0] chip_i = '0, chip_q = '0;
  logic [REL_W-1:0] rel_gain = '0;
  logic llr_vld;
  logic signed [LLR_W-1:0] llr;

  int checks = 0, failures = 0;
  bit done = 0;
  int ref_i, ref_q, hold;
  bit d1_v, d2_v;
  int d1_l, d2_l;
  string d1_t, d2_t;

  always #(CLK_PERIOD / 2) clk = ~clk;

  diff_llr_front dut_i (
    .clk(clk), .rst(rst), .clr(clr), .chip_vld(chip_vld), .chip_i(chip_i),
    .chip_q(chip_q), .rel_mode(rel_mode), .rel_gain(rel_gain),
    .llr_vld(llr_vld), .llr(llr)
  );

  function automatic int exp_llr(int ci, int cq, int pi, int pq, bit known, int g);
    longint dot, s;
    dot = longint'(ci) * pi + longint'(cq) * pq;   // R3
    s = dot * (known ? g : UNITY);                 // R4, R5
    s = s >>> SHIFT;
    if (s > LMAX) s = LMAX;                        // R6
    if (s < LMIN) s = LMIN;
    return int'(s);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  // One cycle: check output due now, then drive new inputs and advance the model.
  task automatic step(bit v, bit c, int i, int q, bit known, int g, string tag);
    @(negedge clk);
    check(llr_vld == d2_v, "R7 valid", int'(llr_vld), int'(d2_v));
    if (d2_v) hold = d2_l;
    check(int'(llr) == hold, d2_v ? d2_t : "R10 hold", int'(llr), hold);
    d2_v = d1_v; d2_l = d1_l; d2_t = d1_t;
    chip_vld = v; clr = c; chip_i = IQ_W'(i); chip_q = IQ_W'(q);
    rel_mode = known; rel_gain = REL_W'(g);
    d1_v = v && !c;
    if (c) begin
      ref_i = ONE; ref_q = 0;                      // R9
    end else if (v) begin
      d1_l = exp_llr(i, q, ref_i, ref_q, known, g);
      d1_t = tag;
      ref_i = i; ref_q = q;
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 1, 0, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_0123;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(llr_vld == 0 && llr == 0, "R1 in reset", int'(llr), 0);
    rst = 0;
    ref_i = ONE; ref_q = 0; hold = 0;
    d1_v = 0; d2_v = 0; d1_l = 0; d2_l = 0; d1_t = ""; d2_t = "";
    step(0, 0, 0, 0, 1, 0, "R1");
    check(llr_vld == 0 && llr == 0, "R1 after reset", int'(llr), 0);
    // R2: first chip against the complex one
    step(1, 0, 300, -500, 1, 16, "R2 first chip");
    idle(3);
    // R3: cross terms with sign
    step(1, 0, -700, 900, 1, 16, "R3 second chip");
    step(1, 0, 512, -256, 1, 40, "R4 gain");
    idle(3);
    // R5: programmed gain ignored in equal-gain mode
    step(1, 0, 1000, 800, 0, 250, "R5 equal gain");
    step(1, 0, 1000, 800, 0, 3, "R5 equal gain");
    idle(3);
    // R6: clamp at both ends
    step(1, 0, 2047, 2047, 1, 255, "R6 sat");
    step(1, 0, 2047, 2047, 1, 255, "R6 sat high");
    step(1, 0, -2048, -2048, 1, 255, "R6 sat low");
    idle(3);
    // R9: clear with a strobe in the same cycle, next chip sees the one
    step(1, 0, 900, 900, 1, 16, "R4");
    step(1, 1, -1500, 300, 1, 16, "R9 dropped");
    step(1, 0, 600, -1200, 1, 16, "R9 after clear");
    idle(3);
    // R8 gaps and back-to-back chips
    step(1, 0, 1200, -300, 1, 20, "R8");
    idle(5);
    step(1, 0, 400, 1100, 1, 20, "R8 after gap");
    step(1, 0, -900, -100, 1, 20, "R7 back to back");
    idle(3);
    for (int n = 0; n < 4000; n++) begin
      bit v, c, k;
      int i, q, g;
      v = ($urandom % 100) < 60;
      c = ($urandom % 100) < 3;
      k = ($urandom % 2) == 1;
      i = int'($urandom % 4096) - 2048;
      q = int'($urandom % 4096) - 2048;
      g = ($urandom % 8 == 0) ? int'($urandom % 256) : int'($urandom % 40);
      step(v, c, i, q, k, g, k ? "R4 random" : "R5 random");
    end
    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule